// File: doc/BRIEF.md
# Acknowledge-Polling Write Completion Sequencer

After an external EEPROM-style memory has been sent a write command closed by STOP, it runs an internal programming cycle. During that cycle it stays silent on the two-wire bus. This sequencer works on the master side. It uses that silence as its busy indicator and does not wait out a fixed worst-case delay. The host asks for a poll. The sequencer then sends START and a write-direction control byte through a byte-level bus master primitive, and repeats this until the slave pulls the acknowledge bit low.

The primitive takes commands on a valid/ready channel: `cmd_valid` with `cmd_op` and `cmd_byte`, accepted when `cmd_ready` is high. It returns one response for every command on a second valid/ready channel: `rsp_valid` with `rsp_nack`, consumed when `rsp_ready` is high. Either side may stall as long as it likes. A command, once offered, stays unchanged until it is accepted, and at most one command is outstanding at a time. The host starts a poll with a `req_valid`/`req_ready` handshake, which is only ready while the sequencer is idle.

On success the sequencer raises `done` and leaves the bus owned, with no STOP sent, so the next read or write can follow at once. If the slave refuses too often, the sequencer releases the bus with STOP and raises `timeout`.

Top module: `ack_poll_seq`

## Requirements
- R1: After reset, `req_ready` is 1, and `busy`, `done`, `timeout`, `cmd_valid` and `rsp_ready` are 0.
- R2: Every poll attempt is a START command (`cmd_op`=0) followed by a byte-send command (`cmd_op`=1). The byte is `{4'b1010, cs, 1'b0}`, where cs is the `req_cs` value captured at request acceptance. Bit 0 is the read/write flag and is always 0.
- R3: A response with `rsp_nack`=1 to the control byte means the slave is busy, and another attempt follows.
- R4: Between attempts, a STOP command (`cmd_op`=2) is sent when `retry_rstart` was 0 at request acceptance. When it was 1, the next START follows directly as a repeated start. Later changes of the pin have no effect on a poll in progress.
- R5: A response with `rsp_nack`=0 to the control byte gives a `done` pulse exactly one cycle long. No STOP or other command follows.
- R6: If attempt number MAX_POLLS is refused, the sequencer sends exactly one STOP and then a one-cycle `timeout` pulse, with no `done`.
- R7: An acknowledge on attempt number MAX_POLLS counts as success (`done`, no `timeout`). `done` and `timeout` are never high together.
- R8: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_op` and `cmd_byte` hold their values.
- R9: `req_ready` is high only while the sequencer is idle, so requests made while busy are held off.
- R10: `busy` rises the cycle after a request is accepted and falls the cycle after `done` or `timeout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host asks for a poll sequence |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| req_cs | input | CS_W | Chip-select bits placed in the control byte |
| retry_rstart | input | 1 | 1: repeated START between attempts; 0: STOP then START |
| busy | output | 1 | Poll sequence in progress |
| done | output | 1 | One-cycle pulse: slave acknowledged, bus still owned |
| timeout | output | 1 | One-cycle pulse: attempt limit reached, bus released |
| cmd_valid | output | 1 | Command offered to the bus primitive |
| cmd_ready | input | 1 | Primitive accepts the command |
| cmd_op | output | 2 | 0 START, 1 send byte, 2 STOP |
| cmd_byte | output | 8 | Byte to send when `cmd_op`=1, else 0 |
| rsp_valid | input | 1 | Primitive reports command completion |
| rsp_ready | output | 1 | Sequencer waiting for a completion |
| rsp_nack | input | 1 | Ninth-bit level for a sent byte (1 = not acknowledged) |

## Verification
Two outcomes can fall on the same response: success, and reaching the attempt limit. This happens when the slave acknowledges exactly on attempt number MAX_POLLS. The bench sweeps the number of refused attempts from zero past the limit, in both retry modes, for all chip-select values and with varied stalls on both channels. The limit-coinciding case must give `done` only, with no trailing STOP. One refusal more must give a single STOP and `timeout` only. The full command sequence of every poll is compared with a list built arithmetically from the refusal count and the mode.

// File: rtl/apoll_pkg.sv
package apoll_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_STOP  = 2'd2
  } bus_op_e;

  typedef enum logic [3:0] {
    S_IDLE      = 4'd0,
    S_START_REQ = 4'd1,
    S_START_RSP = 4'd2,
    S_CTRL_REQ  = 4'd3,
    S_CTRL_RSP  = 4'd4,
    S_STOP_REQ  = 4'd5,
    S_STOP_RSP  = 4'd6,
    S_DONE      = 4'd7,
    S_TOUT      = 4'd8
  } seq_state_e;

endpackage

// File: rtl/apoll_cfg_latch.sv
module apoll_cfg_latch #(
  parameter int CS_W     = 3,
  parameter int DEV_CODE = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [CS_W-1:0] cs_in,
  input  logic            rstart_in,
  output logic [7:0]      ctrl_byte,
  output logic            rstart_q
);
  localparam int CODE_W = 7 - CS_W;
  localparam logic [CODE_W-1:0] CODE_BITS = CODE_W'(DEV_CODE);

  logic [CS_W-1:0] cs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q     <= '0;
      rstart_q <= 1'b0;
    end else if (capture) begin
      cs_q     <= cs_in;
      rstart_q <= rstart_in;
    end
  end

  // Device code in the top bits, select next, direction bit fixed to write.
  assign ctrl_byte = {CODE_BITS, cs_q, 1'b0};

endmodule

// File: rtl/apoll_attempt_ctr.sv
module apoll_attempt_ctr #(
  parameter int MAX_POLLS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic last_try
);
  localparam int CNT_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_POLLS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (bump && (cnt_q != LAST)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Counts refused attempts so far; the current attempt is the last one allowed.
  assign last_try = (cnt_q == LAST);

endmodule

// File: rtl/apoll_fsm.sv
module apoll_fsm
  import apoll_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       rstart_q,
  input  logic       last_try,
  input  logic [7:0] ctrl_byte,
  input  logic       cmd_ready,
  input  logic       rsp_valid,
  input  logic       rsp_nack,
  output logic       req_ready,
  output logic       accept,
  output logic       bump,
  output logic       busy,
  output logic       done,
  output logic       timeout,
  output logic       cmd_valid,
  output bus_op_e    cmd_op,
  output logic [7:0] cmd_byte,
  output logic       rsp_ready
);
  seq_state_e st_q, st_d;
  logic       quit_q, quit_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      quit_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      quit_q <= quit_d;
    end
  end

  always_comb begin
    st_d   = st_q;
    quit_d = quit_q;
    bump   = 1'b0;
    unique case (st_q)
      S_IDLE: if (req_valid) begin
        st_d   = S_START_REQ;
        quit_d = 1'b0;
      end
      S_START_REQ: if (cmd_ready) st_d = S_START_RSP;
      S_START_RSP: if (rsp_valid) st_d = S_CTRL_REQ;
      S_CTRL_REQ:  if (cmd_ready) st_d = S_CTRL_RSP;
      S_CTRL_RSP: if (rsp_valid) begin
        if (!rsp_nack) begin
          st_d = S_DONE;
        end else if (last_try) begin
          quit_d = 1'b1;
          st_d   = S_STOP_REQ;
        end else begin
          bump = 1'b1;
          st_d = rstart_q ? S_START_REQ : S_STOP_REQ;
        end
      end
      S_STOP_REQ: if (cmd_ready) st_d = S_STOP_RSP;
      S_STOP_RSP: if (rsp_valid) st_d = quit_q ? S_TOUT : S_START_REQ;
      S_DONE:     st_d = S_IDLE;
      S_TOUT:     st_d = S_IDLE;
      default:    st_d = S_IDLE;
    endcase
  end

  always_comb begin
    req_ready = (st_q == S_IDLE);
    accept    = req_ready && req_valid;
    busy      = (st_q != S_IDLE);
    done      = (st_q == S_DONE);
    timeout   = (st_q == S_TOUT);
    cmd_valid = (st_q == S_START_REQ) || (st_q == S_CTRL_REQ) || (st_q == S_STOP_REQ);
    rsp_ready = (st_q == S_START_RSP) || (st_q == S_CTRL_RSP) || (st_q == S_STOP_RSP);
    unique case (st_q)
      S_CTRL_REQ: cmd_op = OP_WRITE;
      S_STOP_REQ: cmd_op = OP_STOP;
      default:    cmd_op = OP_START;
    endcase
    cmd_byte = (st_q == S_CTRL_REQ) ? ctrl_byte : 8'h00;
  end

endmodule

// File: rtl/ack_poll_seq.sv
module ack_poll_seq
  import apoll_pkg::*;
#(
  parameter int CS_W      = 3,
  parameter int DEV_CODE  = 10,
  parameter int MAX_POLLS = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [CS_W-1:0] req_cs,
  input  logic            retry_rstart,
  output logic            busy,
  output logic            done,
  output logic            timeout,
  output logic            cmd_valid,
  input  logic            cmd_ready,
  output logic [1:0]      cmd_op,
  output logic [7:0]      cmd_byte,
  input  logic            rsp_valid,
  output logic            rsp_ready,
  input  logic            rsp_nack
);
  logic       accept;
  logic       bump;
  logic       last_try;
  logic       rstart_q;
  logic [7:0] ctrl_byte;
  bus_op_e    op_e;

  apoll_cfg_latch #(
    .CS_W    (CS_W),
    .DEV_CODE(DEV_CODE)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (accept),
    .cs_in    (req_cs),
    .rstart_in(retry_rstart),
    .ctrl_byte(ctrl_byte),
    .rstart_q (rstart_q)
  );

  apoll_attempt_ctr #(
    .MAX_POLLS(MAX_POLLS)
  ) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .bump    (bump),
    .last_try(last_try)
  );

  apoll_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .rstart_q (rstart_q),
    .last_try (last_try),
    .ctrl_byte(ctrl_byte),
    .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid),
    .rsp_nack (rsp_nack),
    .req_ready(req_ready),
    .accept   (accept),
    .bump     (bump),
    .busy     (busy),
    .done     (done),
    .timeout  (timeout),
    .cmd_valid(cmd_valid),
    .cmd_op   (op_e),
    .cmd_byte (cmd_byte),
    .rsp_ready(rsp_ready)
  );

  assign cmd_op = op_e;

endmodule

// File: rtl/apoll_checker.sv
module apoll_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       busy,
  input logic       done,
  input logic       timeout,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic [7:0] cmd_byte
);

  AST_REQ_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> !busy); // R9
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte))); // R8
  AST_WRITE_DIR_LOW: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && cmd_op == 2'd1) |-> (cmd_byte[0] == 1'b0)); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R5
  AST_TOUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) timeout |=> !timeout); // R6
  AST_DONE_TOUT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && timeout)); // R7
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> busy); // R10
  AST_IDLE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n) (done || timeout) |=> !busy); // R10

endmodule

bind ack_poll_seq apoll_checker u_apoll_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .busy     (busy),
  .done     (done),
  .timeout  (timeout),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .cmd_op   (cmd_op),
  .cmd_byte (cmd_byte)
);

// File: tb/test_ack_poll_seq.sv
module test_ack_poll_seq;
  localparam int MAXP = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_ready;
  logic [2:0] req_cs;
  logic       retry_rstart;
  logic       busy, done, timeout;
  logic       cmd_valid, cmd_ready;
  logic [1:0] cmd_op;
  logic [7:0] cmd_byte;
  logic       rsp_valid, rsp_ready, rsp_nack;

  always #5 clk = ~clk;

  ack_poll_seq #(.CS_W(3), .DEV_CODE(10), .MAX_POLLS(MAXP)) i_ack_poll_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cs(req_cs), .retry_rstart(retry_rstart), .busy(busy), .done(done),
    .timeout(timeout), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_byte(cmd_byte), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_nack(rsp_nack)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // responder knobs and log
  int busy_n = 0, bp_cfg = 0, lat_cfg = 1;
  int ctrl_seen = 0, log_n = 0, hold_bad = 0;
  logic [1:0] log_op [0:31];
  logic [7:0] log_byte [0:31];
  int rsp_cd = 0, rdy_wait = 0;
  bit cmd_pend = 0, rsp_pend = 0, nxt_nack = 0;
  bit prev_wait = 0;
  logic [1:0] prev_op;
  logic [7:0] prev_byte;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // Bus primitive model: stalls commands, delays responses, refuses busy_n control bytes.
  initial begin
    cmd_ready = 1'b0; rsp_valid = 1'b0; rsp_nack = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        cmd_ready = 1'b0; rsp_valid = 1'b0; rsp_cd = 0; cmd_pend = 0; rsp_pend = 0; rdy_wait = 0;
        prev_wait = 0;
      end else begin
        if (prev_wait && (!cmd_valid || cmd_op != prev_op || cmd_byte != prev_byte)) hold_bad++;
        if (cmd_pend) begin cmd_ready = 1'b0; rsp_cd = lat_cfg; cmd_pend = 0; rdy_wait = bp_cfg; end
        if (rsp_pend) begin rsp_valid = 1'b0; rsp_nack = 1'b0; rsp_pend = 0; end
        if (rsp_cd > 0) begin
          rsp_cd--;
          if (rsp_cd == 0) begin rsp_valid = 1'b1; rsp_nack = nxt_nack; end
        end
        if (cmd_valid && !cmd_ready && !rsp_valid && rsp_cd == 0) begin
          if (rdy_wait > 0) rdy_wait--; else cmd_ready = 1'b1;
        end
        prev_wait = cmd_valid && !cmd_ready;
        prev_op = cmd_op;
        prev_byte = cmd_byte;
        if (cmd_valid && cmd_ready) begin
          if (log_n < 32) begin log_op[log_n] = cmd_op; log_byte[log_n] = cmd_byte; end
          log_n++;
          nxt_nack = (cmd_op == 2'd1) && (ctrl_seen < busy_n);
          if (cmd_op == 2'd1) ctrl_seen++;
          cmd_pend = 1;
        end
        if (rsp_valid && rsp_ready) rsp_pend = 1;
      end
    end
  end

  task automatic run_one(input int m, input int cs, input int b);
    int dcnt = 0, tcnt = 0, viol = 0, cyc = 0, tail = 0, n_exp = 0, att;
    bit succ;
    logic [1:0] eo [0:31];
    logic [7:0] eb;
    busy_n = b; ctrl_seen = 0; log_n = 0; hold_bad = 0;
    bp_cfg = (cs + b) % 3; lat_cfg = 1 + (cs % 2);
    @(negedge clk);
    req_cs = 3'(cs); retry_rstart = m[0]; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; retry_rstart = ~m[0]; req_cs = ~3'(cs);
    while (tail < 8 && cyc < 3000) begin
      if (done) dcnt++;
      if (timeout) tcnt++;
      if (busy && req_ready) viol++;
      if (dcnt + tcnt > 0) tail++;
      cyc++;
      @(negedge clk);
    end
    // expected command list from refusal count and mode
    succ = (b < MAXP);
    att = succ ? b + 1 : MAXP;
    for (int i = 0; i < att; i++) begin
      eo[n_exp] = 2'd0; n_exp++;
      eo[n_exp] = 2'd1; n_exp++;
      if (i < att - 1 && m == 0) begin eo[n_exp] = 2'd2; n_exp++; end
    end
    if (!succ) begin eo[n_exp] = 2'd2; n_exp++; end
    eb = {4'b1010, 3'(cs), 1'b0};

    chk(cyc < 3000, "R5 sequence ended", cyc, 0);
    chk(log_n == n_exp, (m == 0) ? "R4 command count (stop mode)" : "R4 command count (rstart mode)", log_n, n_exp);
    for (int i = 0; i < n_exp && i < log_n; i++) begin
      chk(log_op[i] == eo[i], "R3 command order", log_op[i], eo[i]);
      if (eo[i] == 2'd1) chk(log_byte[i] == eb, "R2 control byte", log_byte[i], eb);
    end
    if (succ) begin
      chk(dcnt == 1, (b == MAXP - 1) ? "R7 done on last attempt" : "R5 done pulse", dcnt, 1);
      chk(tcnt == 0, (b == MAXP - 1) ? "R7 no timeout on last attempt" : "R5 no timeout", tcnt, 0);
      chk(log_op[n_exp - 1] == 2'd1, "R5 no STOP after ack", log_op[n_exp - 1], 1);
    end else begin
      chk(tcnt == 1, "R6 timeout pulse", tcnt, 1);
      chk(dcnt == 0, "R6 no done", dcnt, 0);
    end
    chk(viol == 0, "R9 req_ready while busy", viol, 0);
    chk(hold_bad == 0, "R8 command held under stall", hold_bad, 0);
    chk(!busy && req_ready, "R10 idle after end", busy, 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_cs = 3'd0; retry_rstart = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    chk({busy, done, timeout, cmd_valid, rsp_ready} == 5'b0, "R1 outputs low",
        {busy, done, timeout, cmd_valid, rsp_ready}, 0);
    for (int m = 0; m < 2; m++)
      for (int cs = 0; cs < 8; cs++)
        for (int b = 0; b <= MAXP + 1; b++)
          run_one(m, cs, b);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R5 actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule